// File: doc/BRIEF.md
# Super Block Framer for a Fixed-Rate Link Lane Group

This block turns a stream of 16-bit link characters into fixed-length error-correction blocks and groups the blocks into super blocks. Every block is 510 characters. The first 502 positions carry payload taken from a valid/ready input. The last 8 positions carry the Reed-Solomon parity characters for that block, which are pulled one per cycle from a side input. The parity itself is computed elsewhere.

The output is a continuous character stream that downstream can stall with a ready signal. Whenever a payload position comes up and no input character is offered, the block emits a fixed filler character. Parity therefore always starts at position 502, whatever the input does. A block-start strobe marks position 0 of every block. A super-block-start strobe marks position 0 of the first block in each group of four. A synchronous reset puts the framer back at position 0 of block 0, and no output is valid while reset is held.

Top module: `sbf_framer`

## Requirements
- R1: While `rst` is high, `outValid`, `inReady` and `parReady` are 0. On the first cycle after `rst` falls, `outValid` is 1 and both `blockStart` and `superStart` are 1.
- R2: At a payload position (0 to 501) with `inValid` high, `outData` equals `inData`, and `inReady` equals `outReady`. The input character is consumed when both are high.
- R3: At a payload position with `inValid` low, `outData` is the filler value 16'hA5C3. No input character is consumed, and the position still advances when `outReady` is high.
- R4: At positions 502 to 509, `outData` equals `parData`, `inReady` is 0, and `parReady` equals `outReady`.
- R5: Each block is exactly 510 accepted output characters long. `blockStart` is 1 exactly at position 0.
- R6: Blocks are numbered 0 to 3 in a repeating cycle. `superStart` is 1 exactly at position 0 of block 0.
- R7: While `outReady` is low, `inReady` and `parReady` are 0, and the position and block number hold. No character is dropped or repeated.
- R8: A reset in the middle of a block restarts framing at position 0 of block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 16 | Payload character |
| inValid | input | 1 | Payload character offered |
| inReady | output | 1 | Payload character taken this cycle when valid |
| parData | input | 16 | Parity character for the current block |
| parReady | output | 1 | Parity character taken this cycle |
| outData | output | 16 | Framed output character |
| outValid | output | 1 | Output character present (high whenever out of reset) |
| outReady | input | 1 | Downstream accepts the output character |
| blockStart | output | 1 | Output character is position 0 of a block |
| superStart | output | 1 | Output character is position 0 of block 0 of a super block |

## Verification
The assertions assume that the parity source has a character ready whenever `parReady` is high, so `parData` is taken as valid in every parity slot. They also assume that `inData` is meaningful only while `inValid` is high. The stimulus drives a fresh `parData` value every cycle. It presents the head of a payload queue on `inData` and holds it there until that character is consumed. Reset is applied only on whole cycles, including once in the middle of a block, so the counters never see a partial reset.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Strobes passed from the framing control to the datapath.
  typedef struct packed {
    logic active;       // out of reset, a character is presented
    logic payloadSlot;  // current position takes payload or filler
    logic paritySlot;   // current position takes parity
    logic blockStart;   // position 0
    logic superStart;   // position 0 of block 0
  } frameCtrl_t;
endpackage

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
#(
  parameter int PAYLOAD_CHARS    = 502,
  parameter int PARITY_CHARS     = 8,
  parameter int BLOCKS_PER_SUPER = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       outReady,
  output frameCtrl_t ctrl
);
  localparam int BLOCK_CHARS = PAYLOAD_CHARS + PARITY_CHARS;
  localparam int POS_W = $clog2(BLOCK_CHARS);
  localparam int BLK_W = (BLOCKS_PER_SUPER > 1) ? $clog2(BLOCKS_PER_SUPER) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLOCK_CHARS - 1);
  localparam logic [POS_W-1:0] FIRST_PARITY = POS_W'(PAYLOAD_CHARS);

  logic [POS_W-1:0] pos;
  logic             blockWrap;
  logic             firstBlk;

  assign blockWrap = !rst && outReady && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (outReady) begin
      if (pos == LAST_POS) pos <= '0;
      else                 pos <= pos + 1'b1;
    end
  end

  generate
    if (BLOCKS_PER_SUPER > 1) begin : gBlkCnt
      localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS_PER_SUPER - 1);
      logic [BLK_W-1:0] blkIdx;
      always_ff @(posedge clk) begin
        if (rst) begin
          blkIdx <= '0;
        end else if (blockWrap) begin
          if (blkIdx == LAST_BLK) blkIdx <= '0;
          else                    blkIdx <= blkIdx + 1'b1;
        end
      end
      assign firstBlk = (blkIdx == '0);
    end else begin : gSingleBlk
      assign firstBlk = 1'b1;
    end
  endgenerate

  always_comb begin
    ctrl.active      = !rst;
    ctrl.payloadSlot = !rst && (pos < FIRST_PARITY);
    ctrl.paritySlot  = !rst && (pos >= FIRST_PARITY);
    ctrl.blockStart  = !rst && (pos == '0);
    ctrl.superStart  = !rst && (pos == '0) && firstBlk;
  end
endmodule

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int              CHAR_W    = 16,
  parameter logic [CHAR_W-1:0] FILL_CHAR = 16'hA5C3
) (
  input  frameCtrl_t        ctrl,
  input  logic [CHAR_W-1:0] inData,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] parData,
  input  logic              outReady,
  output logic [CHAR_W-1:0] outData,
  output logic              outValid,
  output logic              inReady,
  output logic              parReady,
  output logic              blockStart,
  output logic              superStart
);
  always_comb begin
    if (ctrl.paritySlot)   outData = parData;
    else if (inValid)      outData = inData;
    else                   outData = FILL_CHAR;
    outValid   = ctrl.active;
    inReady    = ctrl.payloadSlot && outReady;
    parReady   = ctrl.paritySlot && outReady;
    blockStart = ctrl.blockStart;
    superStart = ctrl.superStart;
  end
endmodule

// File: rtl/sbf_framer.sv
module sbf_framer
  import sbf_pkg::*;
#(
  parameter int                CHAR_W           = 16,
  parameter int                PAYLOAD_CHARS    = 502,
  parameter int                PARITY_CHARS     = 8,
  parameter int                BLOCKS_PER_SUPER = 4,
  parameter logic [CHAR_W-1:0] FILL_CHAR        = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CHAR_W-1:0] parData,
  output logic              parReady,
  output logic [CHAR_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              blockStart,
  output logic              superStart
);
  frameCtrl_t ctrl;

  sbf_ctrl #(
    .PAYLOAD_CHARS   (PAYLOAD_CHARS),
    .PARITY_CHARS    (PARITY_CHARS),
    .BLOCKS_PER_SUPER(BLOCKS_PER_SUPER)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .outReady(outReady),
    .ctrl    (ctrl)
  );

  sbf_datapath #(
    .CHAR_W   (CHAR_W),
    .FILL_CHAR(FILL_CHAR)
  ) uData (
    .ctrl      (ctrl),
    .inData    (inData),
    .inValid   (inValid),
    .parData   (parData),
    .outReady  (outReady),
    .outData   (outData),
    .outValid  (outValid),
    .inReady   (inReady),
    .parReady  (parReady),
    .blockStart(blockStart),
    .superStart(superStart)
  );
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int                CHAR_W           = 16,
  parameter int                PAYLOAD_CHARS    = 502,
  parameter int                PARITY_CHARS     = 8,
  parameter int                BLOCKS_PER_SUPER = 4,
  parameter logic [CHAR_W-1:0] FILL_CHAR        = 16'hA5C3
) (
  input logic              clk,
  input logic              rst,
  input logic [CHAR_W-1:0] inData,
  input logic              inValid,
  input logic              inReady,
  input logic [CHAR_W-1:0] parData,
  input logic              parReady,
  input logic [CHAR_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              blockStart,
  input logic              superStart
);
  localparam int BLOCK_CHARS = PAYLOAD_CHARS + PARITY_CHARS;

  int posSeen;
  int blkSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      posSeen <= 0;
      blkSeen <= 0;
    end else if (outValid && outReady) begin
      if (posSeen == BLOCK_CHARS - 1) begin
        posSeen <= 0;
        blkSeen <= (blkSeen == BLOCKS_PER_SUPER - 1) ? 0 : blkSeen + 1;
      end else begin
        posSeen <= posSeen + 1;
      end
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |-> (!outValid && !inReady && !parReady)); // R1

  AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outValid && blockStart && superStart)); // R8

  AST_PASS_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    (inReady && inValid) |-> (outData == inData)); // R2

  AST_FILL_GAP: assert property (@(posedge clk) disable iff (rst)
    (inReady && !inValid) |-> (outData == FILL_CHAR)); // R3

  AST_PARITY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    parReady |-> (!inReady && outData == parData)); // R4

  AST_PARITY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |-> (parReady == (posSeen >= PAYLOAD_CHARS))); // R4

  AST_BLOCK_START: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (blockStart == (posSeen == 0))); // R5

  AST_SUPER_START: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (superStart == (posSeen == 0 && blkSeen == 0))); // R6

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !outReady |-> (!inReady && !parReady)); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> ($stable(blockStart) && $stable(superStart))); // R7
endmodule

bind sbf_framer sbf_checker #(
  .CHAR_W          (CHAR_W),
  .PAYLOAD_CHARS   (PAYLOAD_CHARS),
  .PARITY_CHARS    (PARITY_CHARS),
  .BLOCKS_PER_SUPER(BLOCKS_PER_SUPER),
  .FILL_CHAR       (FILL_CHAR)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .inData    (inData),
  .inValid   (inValid),
  .inReady   (inReady),
  .parData   (parData),
  .parReady  (parReady),
  .outData   (outData),
  .outValid  (outValid),
  .outReady  (outReady),
  .blockStart(blockStart),
  .superStart(superStart)
);

// File: tb/sim_sbf_framer.sv
module sim_sbf_framer;
  localparam int CLK_PERIOD = 10;
  localparam int PAY = 502;
  localparam int BLK = 510;
  localparam int SB  = 4;
  localparam logic [15:0] FILL = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] parData = '0;
  logic        parReady;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        blockStart;
  logic        superStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int pos = 0;
  int blkIdx = 0;
  logic [15:0] srcQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbf_framer u0 (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
    .parData(parData), .parReady(parReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .blockStart(blockStart), .superStart(superStart)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (pos %0d blk %0d)",
               req, what, act, exp, pos, blkIdx);
    end
  endtask

  // One clock: drive after the falling edge, compare, then advance the model.
  task automatic cycle(input bit r, input bit iv, input bit ordy, input bit afterMidReset);
    string tag;
    logic [15:0] expData;
    bit expIn;
    bit expPar;
    @(negedge clk);
    rst = r;
    outReady = ordy;
    parData = 16'($urandom);
    if (srcQ.size() == 0) srcQ.push_back(16'($urandom));
    inValid = iv;
    inData = srcQ[0];
    #1;
    if (r) begin
      check(32'(outValid), 0, "R1", "outValid in reset");
      check(32'(inReady), 0, "R1", "inReady in reset");
      check(32'(parReady), 0, "R1", "parReady in reset");
      pos = 0;
      blkIdx = 0;
    end else begin
      check(32'(outValid), 1, "R1", "outValid");
      check(32'(blockStart), 32'(pos == 0), afterMidReset ? "R8" : "R5", "blockStart");
      check(32'(superStart), 32'(pos == 0 && blkIdx == 0), afterMidReset ? "R8" : "R6", "superStart");
      if (pos < PAY) begin
        expData = iv ? srcQ[0] : FILL;
        tag = iv ? "R2" : "R3";
        expIn = ordy;
        expPar = 1'b0;
      end else begin
        expData = parData;
        tag = "R4";
        expIn = 1'b0;
        expPar = ordy;
      end
      check(32'(outData), 32'(expData), tag, "outData");
      check(32'(inReady), 32'(expIn), ordy ? tag : "R7", "inReady");
      check(32'(parReady), 32'(expPar), ordy ? tag : "R7", "parReady");
      if (ordy) begin
        if (pos < PAY && iv) void'(srcQ.pop_front());
        pos++;
        if (pos == BLK) begin
          pos = 0;
          blkIdx = (blkIdx + 1) % SB;
        end
      end
    end
  endtask

  initial begin
    // R1: reset holds everything quiet
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0);
    // R2 R4 R5 R6: full-rate stream across more than one super block
    for (int i = 0; i < BLK * 5; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0);
    // R3: gaps in the payload are filled
    for (int i = 0; i < BLK * 4; i++) cycle(1'b0, ($urandom % 4) != 0, 1'b1, 1'b0);
    // R7: downstream stalls, mixed with payload gaps
    for (int i = 0; i < BLK * 3; i++) cycle(1'b0, ($urandom % 3) != 0, ($urandom % 3) != 0, 1'b0);
    // R7: a long stall inside the parity window
    while (pos != PAY + 3) cycle(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 700; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0);
    // R8: reset in the middle of a block
    for (int i = 0; i < 2; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0);
    cycle(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < BLK * 2; i++) cycle(1'b0, ($urandom % 5) != 0, 1'b1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule